// File: doc/BRIEF.md
# Flash Block Read-Protection Register

This block keeps a per-block read/execute permission mask for an on-chip flash array. Each mask bit covers one flash block of `BLOCK_BYTES` bytes. A set bit grants reads and instruction fetches of that block, and a cleared bit withholds them. The default configuration has 32 blocks of 2 KB each, so the protected window is 64 KB.

Software can only tighten protection. A register write can turn ones into zeros, but it can never turn a zero back into a one. A cleared bit is provisional at first: the next power-on reset reloads the live mask from a committed copy. A commit strobe folds the live mask into that committed copy. The committed copy models non-volatile storage, keeps its value across power-on reset and starts at all ones. After a commit, a cleared bit is permanent.

A combinational access-check port takes a flash byte address and reports whether a read of it is allowed. Any address at or past the end of the protected window is refused. A system reset leaves the mask state alone.

Top module: `flash_rdprot_reg`

## Requirements
- R1: While `por_n` is low, the live mask is loaded on every clock edge from the committed copy. The committed copy starts at all ones (0xFFFFFFFF), so the first power-on reset yields all ones.
- R2: `rd_data` shows the live mask combinationally, in the same cycle the mask changes.
- R3: An accepted write (`wr_en` high, both resets inactive) sets the live mask to old mask AND `wr_data` on the next edge. Writing 1 to a 0 bit leaves it 0.
- R4: Bits cleared by writes but never committed return to their committed value after the next power-on reset.
- R5: A committed 0 bit never returns to 1, whatever later writes or resets occur.
- R6: An accepted commit (`commit` high, both resets inactive) sets the committed copy to committed AND live. When a write and a commit fall in the same cycle, the write is applied first and the commit captures the written result.
- R7: For an address below NUM_BLOCKS*BLOCK_BYTES, `chk_allow` equals live mask bit `chk_addr[15:11]` (block index = address / 2048). A bit value of 1 allows access.
- R8: For any address at or above NUM_BLOCKS*BLOCK_BYTES (65536 by default), `chk_allow` is 0.
- R9: While `sys_rst_n` is low and `por_n` is high, writes and commits are ignored, and both the live mask and the committed copy keep their values.
- R10: While `por_n` is low, writes and commits are ignored. Only the reload of R1 takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; reloads the live mask |
| sys_rst_n | input | 1 | System reset, active low; blocks updates, keeps state |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | NUM_BLOCKS | Write data, ANDed into the live mask |
| commit | input | 1 | Commit strobe, folds the live mask into the committed copy |
| chk_addr | input | ADDR_W | Flash byte address to check |
| rd_data | output | NUM_BLOCKS | Live mask read value |
| chk_allow | output | 1 | 1 when a read of `chk_addr` is permitted |

## Verification
A write and a commit can land on the same edge. The bench drives both strobes in one cycle with a clearing write value. It then applies a power-on reset and checks that the reloaded mask contains the written zeros, which shows that the commit captured the post-write value. The same collision is also driven while the system reset is low, and again while power-on reset is low, where the bench checks that neither strobe changes any state. A seeded mix of single and combined strobes then compares the read value and a full address sweep against an arithmetic model after each step.

// File: rtl/flash_rdprot_pkg.sv
package flash_rdprot_pkg;

    typedef enum logic [1:0] {
        LIVE_HOLD   = 2'd0,
        LIVE_RELOAD = 2'd1,
        LIVE_CLEAR  = 2'd2
    } live_op_e;

endpackage

// File: rtl/frp_live_mask.sv
module frp_live_mask
    import flash_rdprot_pkg::*;
#(
    parameter int unsigned NUM_BLOCKS = 32
) (
    input  logic                  clk,
    input  live_op_e              op,
    input  logic [NUM_BLOCKS-1:0] wr_data,
    input  logic [NUM_BLOCKS-1:0] nv_mask,
    output logic [NUM_BLOCKS-1:0] mask_q,
    output logic [NUM_BLOCKS-1:0] mask_nxt
);

    typedef struct packed {
        logic [NUM_BLOCKS-1:0] mask;
    } live_state_t;

    live_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            LIVE_RELOAD: st_d.mask = nv_mask;
            LIVE_CLEAR:  st_d.mask = st_q.mask & wr_data;
            default:     st_d.mask = st_q.mask;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mask_q   = st_q.mask;
    assign mask_nxt = st_d.mask;

endmodule

// File: rtl/frp_nv_store.sv
module frp_nv_store #(
    parameter int unsigned NUM_BLOCKS = 32
) (
    input  logic                  clk,
    input  logic                  commit_en,
    input  logic [NUM_BLOCKS-1:0] live_nxt,
    output logic [NUM_BLOCKS-1:0] nv_mask
);

    typedef struct packed {
        logic [NUM_BLOCKS-1:0] mask;
    } nv_state_t;

    nv_state_t nv_d;
    nv_state_t nv_q = '1;

    always_comb begin
        nv_d = nv_q;
        if (commit_en) begin
            nv_d.mask = nv_q.mask & live_nxt;
        end
    end

    always_ff @(posedge clk) begin
        nv_q <= nv_d;
    end

    assign nv_mask = nv_q.mask;

endmodule

// File: rtl/frp_access_check.sv
module frp_access_check #(
    parameter int unsigned NUM_BLOCKS  = 32,
    parameter int unsigned BLOCK_BYTES = 2048,
    parameter int unsigned ADDR_W      = 20
) (
    input  logic [ADDR_W-1:0]     chk_addr,
    input  logic [NUM_BLOCKS-1:0] mask,
    output logic                  allow
);

    localparam int unsigned IDX_LSB = $clog2(BLOCK_BYTES);
    localparam int unsigned IDX_W   = $clog2(NUM_BLOCKS);
    localparam int unsigned WIN_MSB = IDX_LSB + IDX_W;

    logic [IDX_W-1:0] blk_idx;
    logic             in_window;

    assign blk_idx = chk_addr[WIN_MSB-1:IDX_LSB];

    generate
        if (ADDR_W > WIN_MSB) begin : g_upper
            assign in_window = (chk_addr[ADDR_W-1:WIN_MSB] == '0);
        end else begin : g_full
            assign in_window = 1'b1;
        end
    endgenerate

    assign allow = in_window && mask[blk_idx];

endmodule

// File: rtl/flash_rdprot_reg.sv
module flash_rdprot_reg
    import flash_rdprot_pkg::*;
#(
    parameter int unsigned NUM_BLOCKS  = 32,
    parameter int unsigned BLOCK_BYTES = 2048,
    parameter int unsigned ADDR_W      = 20
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  sys_rst_n,
    input  logic                  wr_en,
    input  logic [NUM_BLOCKS-1:0] wr_data,
    input  logic                  commit,
    input  logic [ADDR_W-1:0]     chk_addr,
    output logic [NUM_BLOCKS-1:0] rd_data,
    output logic                  chk_allow
);

    localparam longint WIN_BYTES = longint'(NUM_BLOCKS) * longint'(BLOCK_BYTES);

    typedef struct packed {
        live_op_e op;
        logic     commit_en;
    } ctrl_t;

    ctrl_t                 ctrl_d;
    logic [NUM_BLOCKS-1:0] live_mask;
    logic [NUM_BLOCKS-1:0] live_nxt;
    logic [NUM_BLOCKS-1:0] nv_mask;

    always_comb begin
        ctrl_d.op        = LIVE_HOLD;
        ctrl_d.commit_en = 1'b0;
        if (!por_n) begin
            ctrl_d.op = LIVE_RELOAD;
        end else if (sys_rst_n) begin
            if (wr_en) begin
                ctrl_d.op = LIVE_CLEAR;
            end
            ctrl_d.commit_en = commit;
        end
    end

    frp_live_mask #(.NUM_BLOCKS(NUM_BLOCKS)) u_live (
        .clk      (clk),
        .op       (ctrl_d.op),
        .wr_data  (wr_data),
        .nv_mask  (nv_mask),
        .mask_q   (live_mask),
        .mask_nxt (live_nxt)
    );

    frp_nv_store #(.NUM_BLOCKS(NUM_BLOCKS)) u_nv (
        .clk       (clk),
        .commit_en (ctrl_d.commit_en),
        .live_nxt  (live_nxt),
        .nv_mask   (nv_mask)
    );

    frp_access_check #(
        .NUM_BLOCKS  (NUM_BLOCKS),
        .BLOCK_BYTES (BLOCK_BYTES),
        .ADDR_W      (ADDR_W)
    ) u_chk (
        .chk_addr (chk_addr),
        .mask     (live_mask),
        .allow    (chk_allow)
    );

    assign rd_data = live_mask;

    // R1
    por_load_chk: assert property (@(posedge clk)
        !por_n |=> (live_mask == $past(nv_mask)));

    // R3
    wr_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && sys_rst_n) |=> (live_mask == ($past(live_mask) & $past(wr_data))));

    // R5
    nv_no_rise_chk: assert property (@(posedge clk) disable iff (!por_n)
        ((nv_mask & ~$past(nv_mask)) == '0));

    // R6
    commit_fold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (commit && sys_rst_n) |=> (nv_mask == ($past(nv_mask) & $past(live_mask) &
                                    ($past(wr_en) ? $past(wr_data) : '1))));

    // R9
    sysrst_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        !sys_rst_n |=> ($stable(live_mask) && $stable(nv_mask)));

    // R8
    oor_deny_chk: assert property (@(posedge clk) disable iff (!por_n)
        (longint'(chk_addr) >= WIN_BYTES) |-> !chk_allow);

endmodule

// File: tb/tb_flash_rdprot_reg.sv
module tb_flash_rdprot_reg;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 32;
    localparam int BLK        = 2048;
    localparam int AW         = 20;
    localparam int WIN        = NB * BLK;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          sys_rst_n = 1'b1;
    logic          wr_en = 1'b0;
    logic [NB-1:0] wr_data = '1;
    logic          commit = 1'b0;
    logic [AW-1:0] chk_addr = '0;
    logic [NB-1:0] rd_data;
    logic          chk_allow;

    int            n_checks = 0;
    int            n_fail   = 0;
    bit            done     = 1'b0;
    logic [NB-1:0] exp_live;
    logic [NB-1:0] exp_nv = '1;
    logic [31:0]   seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_rdprot_reg #(.NUM_BLOCKS(NB), .BLOCK_BYTES(BLK), .ADDR_W(AW)) dut (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .commit    (commit),
        .chk_addr  (chk_addr),
        .rd_data   (rd_data),
        .chk_allow (chk_allow)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic exp_allow(input logic [AW-1:0] a);
        if (int'(a) >= WIN) return 1'b0;
        return exp_live[int'(a) / BLK];
    endfunction

    // one clock with the given controls; inputs driven at negedge, model updated after posedge
    task automatic step(input logic w, input logic [NB-1:0] d, input logic c,
                        input logic p, input logic s);
        @(negedge clk);
        wr_en = w; wr_data = d; commit = c; por_n = p; sys_rst_n = s;
        @(posedge clk);
        if (!p) begin
            exp_live = exp_nv;
        end else if (s) begin
            if (w) exp_live = exp_live & d;
            if (c) exp_nv = exp_nv & exp_live;
        end
        @(negedge clk);
        wr_en = 1'b0; wr_data = '1; commit = 1'b0; por_n = 1'b1; sys_rst_n = 1'b1;
    endtask

    // read value plus a per-block and out-of-window address sweep, controls idle
    task automatic check_state(input string tag);
        check({tag, " R2 rd_data"}, rd_data, exp_live);
        for (int i = 0; i < NB; i++) begin
            chk_addr = AW'(i * BLK + ((i * 37) % BLK));
            #1;
            check({tag, " R7 allow"}, {31'd0, chk_allow}, {31'd0, exp_allow(chk_addr)});
        end
        for (int k = 0; k < 4; k++) begin
            chk_addr = AW'(WIN + k * 70001);
            #1;
            check({tag, " R8 deny"}, {31'd0, chk_allow}, 32'd0);
        end
        chk_addr = '1;
        #1;
        check({tag, " R8 deny top"}, {31'd0, chk_allow}, 32'd0);
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        exp_live = '1;
        // R1: power-on reset from the factory state
        step(1'b1, 32'h0, 1'b1, 1'b0, 1'b1);   // R10: strobes ignored under POR
        step(1'b0, '1, 1'b0, 1'b0, 1'b1);
        check("R1 factory live", rd_data, 32'hFFFF_FFFF);
        check_state("R1");

        // R3: clearing write, then attempt to set bits back
        step(1'b1, 32'hFFFF_0FF0, 1'b0, 1'b1, 1'b1);
        check("R3 clear", rd_data, 32'hFFFF_0FF0);
        step(1'b1, 32'h0000_F00F, 1'b0, 1'b1, 1'b1);
        check("R3 no set", rd_data, 32'h0000_0000);
        check_state("R3");

        // R4: uncommitted clears restored by power-on reset
        step(1'b0, '1, 1'b0, 1'b0, 1'b1);
        check("R4 restore", rd_data, 32'hFFFF_FFFF);

        // R6: write and commit together, write first
        step(1'b1, 32'h7FFF_FFFE, 1'b1, 1'b1, 1'b1);
        check("R6 live", rd_data, 32'h7FFF_FFFE);
        step(1'b0, '1, 1'b0, 1'b0, 1'b1);
        check("R6 committed after POR", rd_data, 32'h7FFF_FFFE);
        check_state("R6");

        // R5: committed zeros survive writes and resets
        step(1'b1, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1);
        check("R5 write ones", rd_data, 32'h7FFF_FFFE);
        step(1'b0, '1, 1'b0, 1'b1, 1'b0);
        step(1'b0, '1, 1'b0, 1'b0, 1'b1);
        check("R5 after resets", rd_data, 32'h7FFF_FFFE);

        // R9: system reset blocks write and commit
        step(1'b1, 32'h0000_FFFF, 1'b1, 1'b1, 1'b0);
        check("R9 live kept", rd_data, 32'h7FFF_FFFE);
        step(1'b1, 32'hFF00_FFFF, 1'b0, 1'b1, 1'b1);
        check("R9 later write", rd_data, 32'h7F00_FFFE);
        step(1'b0, '1, 1'b1, 1'b1, 1'b0);      // commit under system reset
        step(1'b0, '1, 1'b0, 1'b0, 1'b1);
        check("R9 commit ignored", rd_data, 32'h7FFF_FFFE);

        // R10: write+commit under POR ignored
        step(1'b1, 32'h0, 1'b1, 1'b0, 1'b1);
        step(1'b0, '1, 1'b0, 1'b0, 1'b1);
        check("R10 POR strobes ignored", rd_data, 32'h7FFF_FFFE);

        // R6: commit alone folds the live mask
        step(1'b1, 32'hFFFF_FF0F, 1'b0, 1'b1, 1'b1);
        step(1'b0, '1, 1'b1, 1'b1, 1'b1);
        step(1'b0, '1, 1'b0, 1'b0, 1'b1);
        check("R6 commit alone", rd_data, 32'h7FFF_FF0E);

        // R7 R8: exhaustive address sweep at a 256-byte stride
        for (int a = 0; a < (1 << AW); a += 256) begin
            chk_addr = AW'(a + (a % 251));
            #1;
            check("R7/R8 sweep", {31'd0, chk_allow}, {31'd0, exp_allow(chk_addr)});
        end

        // mixed sequence from a seeded generator
        for (int it = 0; it < 150; it++) begin
            logic [31:0] r1, r2, r3;
            seed = nxt(seed); r1 = seed;
            seed = nxt(seed); r2 = seed;
            seed = nxt(seed); r3 = seed;
            step(r1[0] | r1[1], r1 | r2 | r3 | 32'h8421_0000, (r2[3:0] == 4'd0),
                 (r3[2:0] != 3'd0), (r3[5:3] != 3'd0));
            check_state("R3/R6 mix");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule